// File: doc/BRIEF.md
# Instruction Address Sequencer with One-Level Return Register

This block supplies the next fetch address of a small 8-bit-class processor core. A 14-bit program counter steps forward by one whenever the core consumes an instruction or operand byte. It is reloaded with a non-sequential address on a jump, a taken conditional branch, a subroutine call or a subroutine return. The return address of a call is kept in a single shadow register instead of a stack, so only one call level can be outstanding. A second call simply replaces the saved address.

The block also keeps the two processor flags, zero and carry. It uses them to decide whether a conditional branch is taken. The ALU updates the flags through a write strobe. A debug port can overwrite both flags directly, and the flag outputs let the debugger read them back. All interfaces are plain control strobes sampled on the rising clock edge; there is no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `flow_seq`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the program counter and the shadow register are set to 0x3FFD, and both flags are set to 0.
- R2: With `fetch_adv` high and no reload, the program counter increases by one per cycle, wrapping from 0x3FFF to 0x0000. With no strobe at all it holds its value.
- R3: `jmp_go` loads `jmp_dest` into the program counter on the next edge. Any reload overrides `fetch_adv` in the same cycle.
- R4: `call_go` loads `call_dest` into the program counter and saves the return address into the shadow register. The return address is the current program counter, plus one if `fetch_adv` is high in the same cycle.
- R5: `ret_go` copies the shadow register into the program counter and leaves the shadow register unchanged.
- R6: A second call with no return in between overwrites the shadow register. Nothing flags the lost address.
- R7: When several reloads fall in one cycle, the priority is return, then call, then jump, then taken branch. A call that loses to a return does not write the shadow register.
- R8: `br_cond` encodes the test: 0 = taken when C is 0, 1 = taken when C is 1, 2 = taken when Z is 1, 3 = taken when Z is 0. `br_hit` is combinational from `br_go`, `br_cond` and the registered flags, and does not see a flag update in the same cycle. A taken branch loads `br_dest`; an untaken branch leaves the counter to step or hold.
- R9: `alu_flag_we` loads `alu_z`/`alu_c` into the flags on the next edge. The flags are visible at `flag_z`/`flag_c`.
- R10: `dbg_flag_we` loads `dbg_z`/`dbg_c` and wins over `alu_flag_we` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_adv | input | 1 | A byte was fetched; step the counter |
| jmp_go | input | 1 | Unconditional jump strobe |
| jmp_dest | input | 14 | Jump target |
| call_go | input | 1 | Subroutine call strobe |
| call_dest | input | 14 | Call target |
| ret_go | input | 1 | Subroutine return strobe |
| br_go | input | 1 | Conditional branch request |
| br_cond | input | 2 | Branch test selector (R8) |
| br_dest | input | 14 | Branch target |
| alu_flag_we | input | 1 | ALU flag update strobe |
| alu_z | input | 1 | Zero result from ALU |
| alu_c | input | 1 | Carry result from ALU |
| dbg_flag_we | input | 1 | Debug flag write strobe |
| dbg_z | input | 1 | Debug value for zero flag |
| dbg_c | input | 1 | Debug value for carry flag |
| pc | output | 14 | Address of next fetch |
| ret_addr | output | 14 | Shadow return register |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| br_hit | output | 1 | Branch request is taken this cycle |

## Verification
Two pairs of functions can fall in one cycle. A reload can meet a fetch step, and the two flag writers can meet each other. The bench asserts a jump, a call and a taken branch with `fetch_adv` high. It also raises the ALU and debug flag strobes together with opposite values. The next-cycle counter and flags must show only the winning source. A call with the step strobe must save the incremented return address, and a branch together with an ALU flag write must decide on the old flags.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned ADDR_W = 14;
  localparam logic [ADDR_W-1:0] BOOT_VEC = 14'h3FFD;

  typedef enum logic [1:0] {
    COND_C_CLR = 2'd0,
    COND_C_SET = 2'd1,
    COND_Z_SET = 2'd2,
    COND_Z_CLR = 2'd3
  } cond_e;
endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
  import seq_pkg::*;
(
  input  logic       req,
  input  logic [1:0] sel,
  input  logic       z,
  input  logic       c,
  output logic       hit
);
  cond_e code;
  logic  pass;

  always_comb begin
    code = cond_e'(sel);
    unique case (code)
      COND_C_CLR: pass = ~c;
      COND_C_SET: pass = c;
      COND_Z_SET: pass = z;
      COND_Z_CLR: pass = ~z;
      default:    pass = 1'b0;
    endcase
    hit = req & pass;
  end
endmodule

// File: rtl/seq_flags.sv
module seq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic alu_we,
  input  logic alu_z,
  input  logic alu_c,
  input  logic dbg_we,
  input  logic dbg_z,
  input  logic dbg_c,
  output logic z,
  output logic c
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z <= 1'b0;
      c <= 1'b0;
    end else if (dbg_we) begin
      z <= dbg_z;
      c <= dbg_c;
    end else if (alu_we) begin
      z <= alu_z;
      c <= alu_c;
    end
  end
endmodule

// File: rtl/seq_addr.sv
module seq_addr #(
  parameter int unsigned AW = 14,
  parameter logic [AW-1:0] VEC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          save,
  input  logic [AW-1:0] save_addr,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] shadow_q
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q     <= VEC;
      shadow_q <= VEC;
    end else begin
      if (load)      pc_q <= load_addr;
      else if (step) pc_q <= pc_q + ONE;
      if (save)      shadow_q <= save_addr;
    end
  end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import seq_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] RST_VEC = BOOT_VEC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_adv,
  input  logic          jmp_go,
  input  logic [AW-1:0] jmp_dest,
  input  logic          call_go,
  input  logic [AW-1:0] call_dest,
  input  logic          ret_go,
  input  logic          br_go,
  input  logic [1:0]    br_cond,
  input  logic [AW-1:0] br_dest,
  input  logic          alu_flag_we,
  input  logic          alu_z,
  input  logic          alu_c,
  input  logic          dbg_flag_we,
  input  logic          dbg_z,
  input  logic          dbg_c,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] ret_addr,
  output logic          flag_z,
  output logic          flag_c,
  output logic          br_hit
);
  logic          reload;
  logic [AW-1:0] next_addr;
  logic          keep_ret;
  logic [AW-1:0] link_addr;

  seq_cond_eval u_cond (
    .req (br_go),
    .sel (br_cond),
    .z   (flag_z),
    .c   (flag_c),
    .hit (br_hit)
  );

  seq_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .alu_we (alu_flag_we),
    .alu_z  (alu_z),
    .alu_c  (alu_c),
    .dbg_we (dbg_flag_we),
    .dbg_z  (dbg_z),
    .dbg_c  (dbg_c),
    .z      (flag_z),
    .c      (flag_c)
  );

  // Priority: return, call, jump, taken branch
  always_comb begin
    reload    = ret_go | call_go | jmp_go | br_hit;
    next_addr = br_dest;
    if (ret_go)       next_addr = ret_addr;
    else if (call_go) next_addr = call_dest;
    else if (jmp_go)  next_addr = jmp_dest;
    keep_ret  = call_go & ~ret_go;
    link_addr = pc + {{(AW-1){1'b0}}, fetch_adv};
  end

  seq_addr #(.AW(AW), .VEC(RST_VEC)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (fetch_adv),
    .load      (reload),
    .load_addr (next_addr),
    .save      (keep_ret),
    .save_addr (link_addr),
    .pc_q      (pc),
    .shadow_q  (ret_addr)
  );
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int unsigned AW = 14,
  parameter logic [AW-1:0] RST_VEC = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_adv,
  input logic          jmp_go,
  input logic [AW-1:0] jmp_dest,
  input logic          call_go,
  input logic [AW-1:0] call_dest,
  input logic          ret_go,
  input logic          br_go,
  input logic [1:0]    br_cond,
  input logic [AW-1:0] br_dest,
  input logic          alu_flag_we,
  input logic          alu_z,
  input logic          alu_c,
  input logic          dbg_flag_we,
  input logic          dbg_z,
  input logic          dbg_c,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ret_addr,
  input logic          flag_z,
  input logic          flag_c,
  input logic          br_hit
);
  assert_reset_vec_R1: assert property (@(posedge clk)
    !rst_n |=> (pc == RST_VEC && ret_addr == RST_VEC && !flag_z && !flag_c));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_adv && !ret_go && !call_go && !jmp_go && !br_hit)
      |=> pc == AW'($past(pc) + AW'(1)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_adv && !ret_go && !call_go && !jmp_go && !br_hit) |=> $stable(pc));

  assert_jump_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_go && !ret_go && !call_go) |=> pc == $past(jmp_dest));

  assert_call_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (call_go && !ret_go) |=>
      (pc == $past(call_dest) &&
       ret_addr == AW'($past(pc) + AW'($past(fetch_adv)))));

  assert_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_go |=> (pc == $past(ret_addr) && $stable(ret_addr)));

  assert_branch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (br_hit && !ret_go && !call_go && !jmp_go) |=> pc == $past(br_dest));

  assert_nobranch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !br_go |-> !br_hit);

  assert_alu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_flag_we && !dbg_flag_we) |=> (flag_z == $past(alu_z) && flag_c == $past(alu_c)));

  assert_dbg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_flag_we |=> (flag_z == $past(dbg_z) && flag_c == $past(dbg_c)));
endmodule

bind flow_seq seq_chk #(.AW(AW), .RST_VEC(RST_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_adv(fetch_adv),
  .jmp_go(jmp_go), .jmp_dest(jmp_dest),
  .call_go(call_go), .call_dest(call_dest), .ret_go(ret_go),
  .br_go(br_go), .br_cond(br_cond), .br_dest(br_dest),
  .alu_flag_we(alu_flag_we), .alu_z(alu_z), .alu_c(alu_c),
  .dbg_flag_we(dbg_flag_we), .dbg_z(dbg_z), .dbg_c(dbg_c),
  .pc(pc), .ret_addr(ret_addr), .flag_z(flag_z), .flag_c(flag_c),
  .br_hit(br_hit)
);

// File: tb/sim_flow_seq.sv
`timescale 1ns/1ps
module sim_flow_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_adv = 0, jmp_go = 0, call_go = 0, ret_go = 0, br_go = 0;
  logic [13:0] jmp_dest = '0, call_dest = '0, br_dest = '0;
  logic [1:0]  br_cond = '0;
  logic        alu_flag_we = 0, alu_z = 0, alu_c = 0;
  logic        dbg_flag_we = 0, dbg_z = 0, dbg_c = 0;
  logic [13:0] pc, ret_addr;
  logic        flag_z, flag_c, br_hit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  flow_seq u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    fetch_adv = 0; jmp_go = 0; call_go = 0; ret_go = 0; br_go = 0;
    alu_flag_we = 0; dbg_flag_we = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic t_reset();
    repeat (3) step();
    check("R1 pc", pc, 14'h3FFD);
    check("R1 shadow", ret_addr, 14'h3FFD);
    check("R1 flags", {flag_z, flag_c}, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic t_advance();
    fetch_adv = 1; step(); check("R2 step", pc, 14'h3FFE);
    fetch_adv = 1; step(); check("R2 step", pc, 14'h3FFF);
    fetch_adv = 1; step(); check("R2 wrap", pc, 14'h0000);
    step();                check("R2 hold", pc, 14'h0000);
  endtask

  task automatic t_jump();
    jmp_go = 1; jmp_dest = 14'h0100; fetch_adv = 1; step();
    check("R3 jump beats step", pc, 14'h0100);
  endtask

  task automatic t_call_ret();
    call_go = 1; call_dest = 14'h0200; fetch_adv = 1; step();
    check("R4 call pc", pc, 14'h0200);
    check("R4 call link with step", ret_addr, 14'h0101);
    call_go = 1; call_dest = 14'h0300; step();
    check("R6 nested pc", pc, 14'h0300);
    check("R6 nested overwrite", ret_addr, 14'h0200);
    ret_go = 1; fetch_adv = 1; step();
    check("R5 return pc", pc, 14'h0200);
    check("R5 shadow kept", ret_addr, 14'h0200);
  endtask

  task automatic t_priority();
    jmp_go = 1; jmp_dest = 14'h0400; step();
    ret_go = 1; jmp_go = 1; jmp_dest = 14'h0500; step();
    check("R7 ret over jump", pc, 14'h0200);
    call_go = 1; call_dest = 14'h0600; jmp_go = 1; jmp_dest = 14'h0700; step();
    check("R7 call over jump", pc, 14'h0600);
    check("R7 call link", ret_addr, 14'h0200);
    ret_go = 1; call_go = 1; call_dest = 14'h0800; step();
    check("R7 ret over call pc", pc, 14'h0200);
    check("R7 losing call no save", ret_addr, 14'h0200);
  endtask

  task automatic t_flags();
    alu_flag_we = 1; alu_z = 1; alu_c = 0; step();
    check("R9 alu write", {flag_z, flag_c}, 2'b10);
    alu_flag_we = 1; alu_z = 1; alu_c = 0;
    dbg_flag_we = 1; dbg_z = 0; dbg_c = 1; step();
    check("R10 debug wins", {flag_z, flag_c}, 2'b01);
  endtask

  task automatic t_branch();
    // flags Z=0 C=1, pc 0x0200
    br_go = 1; br_cond = 2'd0; br_dest = 14'h0A00; fetch_adv = 1; #1;
    check("R8 c-clear not taken", br_hit, 1'b0);
    step(); check("R8 untaken steps", pc, 14'h0201);
    br_go = 1; br_cond = 2'd1; br_dest = 14'h0B00; fetch_adv = 1; #1;
    check("R8 c-set taken", br_hit, 1'b1);
    step(); check("R8 taken load", pc, 14'h0B00);
    br_go = 1; br_cond = 2'd2; br_dest = 14'h0C00; fetch_adv = 1; #1;
    check("R8 z-set not taken", br_hit, 1'b0);
    step(); check("R8 untaken steps", pc, 14'h0B01);
    br_go = 1; br_cond = 2'd3; br_dest = 14'h0C00; #1;
    check("R8 z-clear taken", br_hit, 1'b1);
    step(); check("R8 taken load", pc, 14'h0C00);
    alu_flag_we = 1; alu_z = 1; alu_c = 0; step();
    br_go = 1; br_cond = 2'd2; br_dest = 14'h0D00; #1;
    check("R8 z-set taken", br_hit, 1'b1);
    step(); check("R8 taken load", pc, 14'h0D00);
    br_go = 1; br_cond = 2'd0; br_dest = 14'h0E00; jmp_go = 1; jmp_dest = 14'h0F00; #1;
    check("R8 c-clear taken", br_hit, 1'b1);
    step(); check("R7 jump over branch", pc, 14'h0F00);
    br_go = 1; br_cond = 2'd3; br_dest = 14'h1000; fetch_adv = 1;
    alu_flag_we = 1; alu_z = 0; alu_c = 0; #1;
    check("R8 old flags used", br_hit, 1'b0);
    step(); check("R8 untaken steps", pc, 14'h0F01);
    check("R9 flag after branch", {flag_z, flag_c}, 2'b00);
  endtask

  initial begin
    #1;
    t_reset();
    t_advance();
    t_jump();
    t_call_ret();
    t_priority();
    t_flags();
    t_branch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule